// File: doc/BRIEF.md
# Scaled-Toggle Vertical Clock Generator

This block drives one vertical transfer clock for an image-sensor readout timing path. Toggle points are not written in pixels. They are written in units of a programmable step length, so a wide pulse needs only small register values. A pixel counter restarts on every horizontal sync pulse. When that counter reaches the group start pixel, a sub-counter begins cycling through the step length. A coarse counter advances each time the sub-counter wraps.

The output begins at the programmed start polarity. It inverts each time the coarse count lands on an enabled toggle value while the sub-counter is at zero. That makes the effective toggle pixel equal to the start pixel plus the toggle value times the step length. With sweep disabled, every line starts the pattern again. With sweep enabled, the pattern keeps running across line boundaries.

Top module: `vclk_scaled_gen`

## Requirements
- R1: While reset is held, and after it until the first toggle, `vout_o` equals `start_pol_i`.
- R2: `vout_o` is `start_pol_i` XOR the parity of the toggles taken so far. A change of `start_pol_i` is seen on `vout_o` in the same cycle.
- R3: Line pixel 0 is the first cycle after the cycle in which `hd_i` is high. The pattern starts (position 0) at line pixel `start_pix_i`. A toggle with value T and step length L is taken at position T*L and is seen on `vout_o` one cycle later. Example: L=4, T=2 and T=9, start 0 gives changes seen at line pixels 9 and 37.
- R4: A step length `len_i` of 0 behaves exactly like a step length of 1. Step lengths up to 255 are honoured.
- R5: There are three toggle slots. Slot i takes its value from `tog_vals_i[12*i+11:12*i]` and is enabled by `tog_en_i[i]`. A disabled slot never changes the output.
- R6: With `sweep_en_i` low, an `hd_i` cycle clears the toggle parity and stops the pattern. `vout_o` equals `start_pol_i` at line pixel 0, and the pattern restarts at the start pixel of the new line.
- R7: With `sweep_en_i` high, an `hd_i` cycle does not disturb a running pattern. Positions keep counting one per cycle across the line boundary.
- R8: A toggle value of 0 is taken at the start pixel itself. Two enabled slots with equal values are taken in the same cycle and cancel each other.
- R9: The coarse counter stops one past the largest 12-bit value. After position 4095*L, no further toggle is ever taken until a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd_i | input | 1 | Horizontal sync, one cycle high per line |
| sweep_en_i | input | 1 | 1: pattern runs across line boundaries |
| start_pol_i | input | 1 | Output level before the first toggle |
| start_pix_i | input | 12 | Line pixel at which the pattern starts |
| len_i | input | 8 | Step length in pixels (0 treated as 1) |
| tog_vals_i | input | 36 | Three 12-bit toggle values, slot 0 in the low bits |
| tog_en_i | input | 3 | Per-slot enable, bit i for slot i |
| vout_o | output | 1 | Vertical clock output |

## Verification
The assertions assume that `hd_i` is a single-cycle pulse. They also assume that the step length and the start pixel stay fixed while a pattern runs, so a reload always happens before a new configuration matters. The stimulus changes configuration only at a line boundary with sweep low, immediately before an `hd_i` pulse. It turns sweep on only in the pixel-0 cycle that follows such a reload. Each sweep test then keeps its configuration unchanged for its whole run.

// File: rtl/vclk_pkg.sv
package vclk_pkg;
    localparam int PIX_W_DEF = 12;
    localparam int LEN_W_DEF = 8;
    localparam int CRS_W_DEF = 12;
    localparam int NTOG_DEF  = 3;

    typedef enum logic {
        U_IDLE = 1'b0,
        U_RUN  = 1'b1
    } unit_phase_e;
endpackage

// File: rtl/vclk_line_ctr.sv
module vclk_line_ctr #(
    parameter int PIX_W = vclk_pkg::PIX_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hd_i,
    input  logic [PIX_W-1:0] start_pix_i,
    output logic             start_hit_o
);
    localparam logic [PIX_W-1:0] PIX_MAX = {PIX_W{1'b1}};

    typedef struct packed {
        logic [PIX_W-1:0] pix;
    } line_s;

    line_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hd_i) begin
            st_d.pix = '0;
        end else if (st_q.pix != PIX_MAX) begin
            st_d.pix = st_q.pix + 1'b1;
        end
        start_hit_o = (st_q.pix == start_pix_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    a_r3_line_origin: assert property (@(posedge clk) disable iff (!rst_n)
        hd_i |=> (st_q.pix == '0));

    a_r3_pix_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !hd_i |=> (st_q.pix >= $past(st_q.pix)));
endmodule

// File: rtl/vclk_unit_ctr.sv
module vclk_unit_ctr #(
    parameter int LEN_W = vclk_pkg::LEN_W_DEF,
    parameter int CRS_W = vclk_pkg::CRS_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_i,
    input  logic             start_hit_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             cur_act_o,
    output logic [LEN_W-1:0] cur_sub_o,
    output logic [CRS_W:0]   cur_crs_o
);
    import vclk_pkg::*;

    localparam logic [CRS_W:0] CRS_CAP = {1'b1, {CRS_W{1'b0}}};

    typedef struct packed {
        unit_phase_e      phase;
        logic [LEN_W-1:0] sub;
        logic [CRS_W:0]   crs;
    } unit_s;

    unit_s            st_d, st_q;
    logic [LEN_W-1:0] len_eff;
    logic             running;

    always_comb begin
        len_eff   = (len_i == '0) ? {{(LEN_W-1){1'b0}}, 1'b1} : len_i;
        running   = (st_q.phase == U_RUN);
        cur_act_o = running || start_hit_i;
        cur_sub_o = running ? st_q.sub : '0;
        cur_crs_o = running ? st_q.crs : '0;

        st_d = st_q;
        if (reload_i) begin
            st_d.phase = U_IDLE;
            st_d.sub   = '0;
            st_d.crs   = '0;
        end else if (cur_act_o) begin
            st_d.phase = U_RUN;
            if (cur_sub_o >= len_eff - 1'b1) begin
                st_d.sub = '0;
                st_d.crs = (cur_crs_o == CRS_CAP) ? cur_crs_o : cur_crs_o + 1'b1;
            end else begin
                st_d.sub = cur_sub_o + 1'b1;
                st_d.crs = cur_crs_o;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: U_IDLE, sub: '0, crs: '0};
        end else begin
            st_q <= st_d;
        end
    end

    a_r6_reload_clears: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> (st_q.phase == U_IDLE && st_q.sub == '0 && st_q.crs == '0));

    a_r7_run_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload_i && cur_act_o) |=> cur_act_o);

    a_r9_cap_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload_i && st_q.phase == U_RUN && st_q.crs == CRS_CAP) |=> (st_q.crs == CRS_CAP));

    a_r3_coarse_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == U_RUN && st_q.crs != $past(st_q.crs)) |-> (st_q.sub == '0));
endmodule

// File: rtl/vclk_tog_match.sv
module vclk_tog_match #(
    parameter int NTOG  = vclk_pkg::NTOG_DEF,
    parameter int LEN_W = vclk_pkg::LEN_W_DEF,
    parameter int CRS_W = vclk_pkg::CRS_W_DEF
) (
    input  logic                  block_i,
    input  logic                  cur_act_i,
    input  logic [LEN_W-1:0]      cur_sub_i,
    input  logic [CRS_W:0]        cur_crs_i,
    input  logic [NTOG*CRS_W-1:0] tog_vals_i,
    input  logic [NTOG-1:0]       tog_en_i,
    output logic [NTOG-1:0]       hit_o,
    output logic                  flip_o
);
    logic at_boundary;

    assign at_boundary = cur_act_i && !block_i && (cur_sub_i == '0);

    for (genvar gi = 0; gi < NTOG; gi++) begin : g_slot
        logic [CRS_W-1:0] val;
        assign val       = tog_vals_i[gi*CRS_W +: CRS_W];
        assign hit_o[gi] = at_boundary && tog_en_i[gi] && (cur_crs_i == {1'b0, val});
    end

    assign flip_o = ^hit_o;

    always_comb begin
        a_r5_disabled_silent: assert ((hit_o & ~tog_en_i) == '0);
    end
endmodule

// File: rtl/vclk_scaled_gen.sv
module vclk_scaled_gen #(
    parameter int PIX_W = vclk_pkg::PIX_W_DEF,
    parameter int LEN_W = vclk_pkg::LEN_W_DEF,
    parameter int CRS_W = vclk_pkg::CRS_W_DEF,
    parameter int NTOG  = vclk_pkg::NTOG_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hd_i,
    input  logic                  sweep_en_i,
    input  logic                  start_pol_i,
    input  logic [PIX_W-1:0]      start_pix_i,
    input  logic [LEN_W-1:0]      len_i,
    input  logic [NTOG*CRS_W-1:0] tog_vals_i,
    input  logic [NTOG-1:0]       tog_en_i,
    output logic                  vout_o
);
    typedef struct packed {
        logic par;
    } out_s;

    out_s             st_d, st_q;
    logic             reload;
    logic             start_hit;
    logic             cur_act;
    logic [LEN_W-1:0] cur_sub;
    logic [CRS_W:0]   cur_crs;
    logic [NTOG-1:0]  hit;
    logic             flip;

    assign reload = hd_i && !sweep_en_i;

    vclk_line_ctr #(.PIX_W(PIX_W)) u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .hd_i        (hd_i),
        .start_pix_i (start_pix_i),
        .start_hit_o (start_hit)
    );

    vclk_unit_ctr #(.LEN_W(LEN_W), .CRS_W(CRS_W)) u_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .reload_i    (reload),
        .start_hit_i (start_hit),
        .len_i       (len_i),
        .cur_act_o   (cur_act),
        .cur_sub_o   (cur_sub),
        .cur_crs_o   (cur_crs)
    );

    vclk_tog_match #(.NTOG(NTOG), .LEN_W(LEN_W), .CRS_W(CRS_W)) u_match (
        .block_i    (reload),
        .cur_act_i  (cur_act),
        .cur_sub_i  (cur_sub),
        .cur_crs_i  (cur_crs),
        .tog_vals_i (tog_vals_i),
        .tog_en_i   (tog_en_i),
        .hit_o      (hit),
        .flip_o     (flip)
    );

    always_comb begin
        st_d = st_q;
        if (reload) begin
            st_d.par = 1'b0;
        end else begin
            st_d.par = st_q.par ^ flip;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vout_o = start_pol_i ^ st_q.par;

    a_r3_flip_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.par != $past(st_q.par)) |-> ($past(reload) || $past(cur_sub) == '0));

    a_r6_line_reload: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (vout_o == start_pol_i));

    a_r7_sweep_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en_i && hd_i && cur_act) |=> cur_act);

    a_r8_cancel_pair: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(hit) == 2) |=> (st_q.par == $past(st_q.par)));
endmodule

// File: tb/sim_vclk_scaled_gen.sv
module sim_vclk_scaled_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hd_i = 1'b0;
    logic        sweep_en_i = 1'b0;
    logic        start_pol_i = 1'b1;
    logic [11:0] start_pix_i = 12'hfff;
    logic [7:0]  len_i = 8'd1;
    logic [35:0] tog_vals_i = '0;
    logic [2:0]  tog_en_i = '0;
    logic        vout_o;

    int total = 0;
    int bad = 0;
    int px = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    vclk_scaled_gen u0 (
        .clk(clk), .rst_n(rst_n), .hd_i(hd_i), .sweep_en_i(sweep_en_i),
        .start_pol_i(start_pol_i), .start_pix_i(start_pix_i), .len_i(len_i),
        .tog_vals_i(tog_vals_i), .tog_en_i(tog_en_i), .vout_o(vout_o)
    );

    typedef struct packed {
        logic [7:0]  len;
        logic [11:0] start;
        logic [11:0] t0;
        logic [11:0] t1;
        logic [11:0] t2;
        logic [2:0]  en;
        logic        pol;
        logic [15:0] first;
        logic [15:0] second;
        logic [31:0] tag;
    } vec_t;

    // first/second: line pixel at which vout_o first shows the change (0 = none)
    localparam vec_t TBL [5] = '{
        '{8'd4,   12'd0, 12'd2, 12'd9, 12'd0, 3'b011, 1'b0, 16'd9, 16'd37,  3},
        '{8'd0,   12'd5, 12'd3, 12'd7, 12'd0, 3'b011, 1'b1, 16'd9, 16'd13,  4},
        '{8'd3,   12'd2, 12'd1, 12'd4, 12'd6, 3'b101, 1'b0, 16'd6, 16'd21,  5},
        '{8'd2,   12'd1, 12'd0, 12'd5, 12'd5, 3'b111, 1'b0, 16'd2, 16'd0,   8},
        '{8'd255, 12'd0, 12'd0, 12'd1, 12'd0, 3'b011, 1'b1, 16'd1, 16'd256, 4}
    };

    task automatic chk(input string req, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: vout_o=%0b expected=%0b (pixel %0d)", req, got, exp, px);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic hd_pulse();
        step();
        hd_i = 1'b1;
        step();
        hd_i = 1'b0;
        px = 0;
    endtask

    task automatic goto(input int k);
        while (px < k) begin
            step();
            px++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset level follows start polarity
        step();
        step();
        chk("R1", vout_o, 1'b1);
        rst_n = 1'b1;
        step();
        chk("R1", vout_o, 1'b1);
        // R2: polarity input shows in the same cycle
        start_pol_i = 1'b0;
        #1;
        chk("R2", vout_o, 1'b0);

        // R3 R4 R5 R8: table of configurations, sweep off
        for (int v = 0; v < 5; v++) begin
            len_i       = TBL[v].len;
            start_pix_i = TBL[v].start;
            tog_vals_i  = {TBL[v].t2, TBL[v].t1, TBL[v].t0};
            tog_en_i    = TBL[v].en;
            start_pol_i = TBL[v].pol;
            sweep_en_i  = 1'b0;
            hd_pulse();
            chk($sformatf("R%0d pre", TBL[v].tag), vout_o, TBL[v].pol);
            goto(int'(TBL[v].first) - 1);
            chk($sformatf("R%0d first-1", TBL[v].tag), vout_o, TBL[v].pol);
            goto(int'(TBL[v].first));
            chk($sformatf("R%0d first", TBL[v].tag), vout_o, ~TBL[v].pol);
            if (TBL[v].second != 0) begin
                goto(int'(TBL[v].second) - 1);
                chk($sformatf("R%0d second-1", TBL[v].tag), vout_o, ~TBL[v].pol);
                goto(int'(TBL[v].second));
                chk($sformatf("R%0d second", TBL[v].tag), vout_o, TBL[v].pol);
            end else begin
                goto(40);
                chk($sformatf("R%0d equal pair cancels", TBL[v].tag), vout_o, ~TBL[v].pol);
            end
            goto(290);
        end

        // R6: sweep off, hd restores polarity and restarts pattern
        len_i = 8'd1; start_pix_i = 12'd5; tog_vals_i = {12'd0, 12'd0, 12'd3};
        tog_en_i = 3'b001; start_pol_i = 1'b0; sweep_en_i = 1'b0;
        hd_pulse();
        goto(20);
        chk("R6 toggled", vout_o, 1'b1);
        hd_pulse();
        chk("R6 reload at pixel 0", vout_o, 1'b0);
        goto(8);
        chk("R6 restart pre", vout_o, 1'b0);
        goto(9);
        chk("R6 restart", vout_o, 1'b1);

        // R7: sweep on, pattern crosses hd pulses every 30 cycles
        len_i = 8'd4; start_pix_i = 12'd2; tog_vals_i = {12'd0, 12'd20, 12'd2};
        tog_en_i = 3'b011; start_pol_i = 1'b0;
        hd_pulse();
        sweep_en_i = 1'b1;
        for (int c = 1; c <= 90; c++) begin
            step();
            if (c == 10) chk("R7 before first", vout_o, 1'b0);
            if (c == 11) chk("R7 first", vout_o, 1'b1);
            if (c == 82) chk("R7 across lines", vout_o, 1'b1);
            if (c == 83) chk("R7 second", vout_o, 1'b0);
            hd_i = (c % 30 == 0);
        end
        hd_i = 1'b0;

        // R9: coarse counter stops; no toggle beyond the 12-bit range
        sweep_en_i = 1'b0;
        len_i = 8'd0; start_pix_i = 12'd0; tog_vals_i = {12'd0, 12'd0, 12'd4095};
        tog_en_i = 3'b001; start_pol_i = 1'b1;
        hd_pulse();
        sweep_en_i = 1'b1;
        goto(4095);
        chk("R9 before last", vout_o, 1'b1);
        goto(4096);
        chk("R9 last value", vout_o, 1'b0);
        goto(9000);
        chk("R9 no wrap", vout_o, 1'b0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule